// File: doc/BRIEF.md
# Coprocessor-0 command decoder

This block sits in the execute stage of a small processor core and handles the instruction words that target system coprocessor 0. An instruction word and its PC are presented together with a valid strobe. One clock later the block reports a registered result. The result says whether the word was a register move, a return-from-exception, an interrupt enable, an interrupt disable or a no-operation-class command. It also gives the PC of the next instruction and a retire pulse. A word that fits none of these patterns produces a report carrying its PC and its encoding instead.

Among the Status register fields, the block models only the interrupt-enable bit (bit 16). The enable instruction sets that bit, the disable instruction clears it, and a register move can read or write it. This lets the surrounding core see the effect of EI and DI. TLB commands and waiting are accepted and retired, but they have no effect. Delivering interrupts is left to other logic.

Top module: `cop0_cmd_decoder`

## Requirements
- R1: After reset, `retire_o`, `unsup_o`, every class flag and `status_ie_o` are 0, and `next_pc_o` is 0.
- R2: Bits 31:26 must equal 0x10 to select coprocessor 0. Bits 25:21 then select the group: 0x00 is move-from (MFC0), 0x04 is move-to (MTC0) and 0x10 is the command group. The command group also requires bits 24:6 to be zero, and a move requires bits 10:0 to be zero. Any other word is unsupported.
- R3: Command function 0x38 (bits 5:0) decodes as EI, so the word 0x42000038 is EI. EI retires with `is_ei_o` set and `next_pc_o` = PC + 4.
- R4: A retired EI leaves Status bit 16 (`status_ie_o`) at 1.
- R5: Command function 0x39 decodes as DI. DI retires with `is_di_o` set and PC + 4, and it leaves `status_ie_o` at 0.
- R6: MFC0 retires with PC + 4. When its rd field (bits 15:11) is 12, `rdata_o` carries the enable bit as held before the instruction, in bit 16, with every other bit 0. For any other rd, `rdata_o` is 0. `gpr_idx_o` carries bits 20:16.
- R7: MTC0 retires with PC + 4. When rd is 12, it loads `status_ie_o` from `mt_ie_i`. For any other rd, it leaves the bit unchanged.
- R8: Command function 0x10 is a return-from-exception. It retires with `is_rfe_o` and PC + 4, and it leaves `status_ie_o` unchanged.
- R9: Command functions 0x01, 0x02, 0x06, 0x08, 0x18 and 0x20 retire with only `is_nop_o` set and PC + 4, and they leave `status_ie_o` unchanged.
- R10: An unsupported word raises `unsup_o` for one cycle, with `unsup_pc_o` and `unsup_instr_o` holding its PC and encoding. It does not retire, and it leaves `next_pc_o` and `status_ie_o` unchanged.
- R11: Results appear in the cycle after the valid edge. A retire carries exactly one class flag, and no flag is set without a retire.
- R12: While `instr_valid_i` is low, neither `retire_o` nor `unsup_o` rises and `status_ie_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Instruction word and PC are valid this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | PC of the instruction |
| mt_ie_i | input | 1 | Enable-bit value carried by a move-to |
| retire_o | output | 1 | Instruction retired |
| is_mfc0_o | output | 1 | Class: move from coprocessor |
| is_mtc0_o | output | 1 | Class: move to coprocessor |
| is_rfe_o | output | 1 | Class: return from exception |
| is_ei_o | output | 1 | Class: interrupt enable |
| is_di_o | output | 1 | Class: interrupt disable |
| is_nop_o | output | 1 | Class: no-operation command |
| next_pc_o | output | 32 | PC of the next instruction |
| rdata_o | output | 32 | Move-from read data |
| gpr_idx_o | output | 5 | General register index of a move |
| status_ie_o | output | 1 | Status interrupt-enable bit |
| unsup_o | output | 1 | Unsupported instruction reported |
| unsup_pc_o | output | 32 | PC of the last unsupported word |
| unsup_instr_o | output | 32 | Encoding of the last unsupported word |

## Verification
The assertions assume that `pc_i`, `instr_i` and `mt_ie_i` are stable around each rising edge, and that reset is held for at least one edge before the first valid strobe. The PC-step check also assumes that the PC held in the flop came from the same edge as the strobe. The bench drives every input on the falling edge and raises the strobe for one cycle per word. It samples results on the next falling edge and keeps the strobe low while reset is asserted.

// File: rtl/cop0_cmd_pkg.sv
package cop0_cmd_pkg;

  localparam logic [5:0] OPC_COP0   = 6'h10;
  localparam logic [4:0] SEL_MOVE_F = 5'h00;
  localparam logic [4:0] SEL_MOVE_T = 5'h04;
  localparam logic [4:0] SEL_CMD    = 5'h10;

  localparam logic [5:0] FN_TLB_RD  = 6'h01;
  localparam logic [5:0] FN_TLB_WI  = 6'h02;
  localparam logic [5:0] FN_TLB_WR  = 6'h06;
  localparam logic [5:0] FN_TLB_PR  = 6'h08;
  localparam logic [5:0] FN_RET_EXC = 6'h10;
  localparam logic [5:0] FN_ERET    = 6'h18;
  localparam logic [5:0] FN_WAIT    = 6'h20;
  localparam logic [5:0] FN_IRQ_ON  = 6'h38;
  localparam logic [5:0] FN_IRQ_OFF = 6'h39;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_MFC0,
    CLS_MTC0,
    CLS_RFE,
    CLS_EI,
    CLS_DI,
    CLS_NOP
  } cmd_cls_e;

endpackage

// File: rtl/cop0_cmd_classify.sv
module cop0_cmd_classify
  import cop0_cmd_pkg::*;
(
  input  logic [31:0] instr_i,
  output cmd_cls_e    cls_o,
  output logic [4:0]  rd_idx_o,
  output logic [4:0]  rt_idx_o
);

  logic [5:0] opc;
  logic [4:0] sel;
  logic [5:0] fn;
  logic       cmd_pad_zero;
  logic       move_pad_zero;
  logic       is_cop0;

  always_comb begin
    opc           = instr_i[31:26];
    sel           = instr_i[25:21];
    fn            = instr_i[5:0];
    rt_idx_o      = instr_i[20:16];
    rd_idx_o      = instr_i[15:11];
    cmd_pad_zero  = (instr_i[24:6] == 19'd0);
    move_pad_zero = (instr_i[10:0] == 11'd0);
    is_cop0       = (opc == OPC_COP0);
  end

  always_comb begin
    cls_o = CLS_NONE;
    if (is_cop0) begin
      unique case (sel)
        SEL_MOVE_F: if (move_pad_zero) cls_o = CLS_MFC0;
        SEL_MOVE_T: if (move_pad_zero) cls_o = CLS_MTC0;
        SEL_CMD: begin
          if (cmd_pad_zero) begin
            unique case (fn)
              FN_IRQ_ON:  cls_o = CLS_EI;
              FN_IRQ_OFF: cls_o = CLS_DI;
              FN_RET_EXC: cls_o = CLS_RFE;
              FN_TLB_RD, FN_TLB_WI, FN_TLB_WR, FN_TLB_PR,
              FN_ERET, FN_WAIT: cls_o = CLS_NOP;
              default:    cls_o = CLS_NONE;
            endcase
          end
        end
        default: cls_o = CLS_NONE;
      endcase
    end
  end

endmodule

// File: rtl/cop0_status_ie.sv
module cop0_status_ie
  import cop0_cmd_pkg::*;
#(
  parameter int          STATUS_IDX = 12,
  parameter bit          EI_SETS_IE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  cmd_cls_e   cls_i,
  input  logic [4:0] rd_idx_i,
  input  logic       mt_ie_i,
  output logic       ie_o
);

  localparam logic [4:0] STATUS_SEL = 5'(STATUS_IDX);

  logic ie_q;
  logic ie_d;
  logic ie_en;

  generate
    if (EI_SETS_IE) begin : g_irq_ctl
      always_comb begin
        ie_en = 1'b0;
        ie_d  = ie_q;
        if (en_i) begin
          unique case (cls_i)
            CLS_EI: begin ie_en = 1'b1; ie_d = 1'b1; end
            CLS_DI: begin ie_en = 1'b1; ie_d = 1'b0; end
            CLS_MTC0: if (rd_idx_i == STATUS_SEL) begin
              ie_en = 1'b1;
              ie_d  = mt_ie_i;
            end
            default: ie_en = 1'b0;
          endcase
        end
      end

      AST_EI_SETS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && cls_i == CLS_EI) |=> ie_o) else $error("EI did not set enable"); // R4
      AST_DI_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && cls_i == CLS_DI) |=> !ie_o) else $error("DI did not clear enable"); // R5
    end else begin : g_move_only
      always_comb begin
        ie_en = en_i && (cls_i == CLS_MTC0) && (rd_idx_i == STATUS_SEL);
        ie_d  = ie_en ? mt_ie_i : ie_q;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
    end else if (ie_en) begin
      ie_q <= ie_d;
    end
  end

  assign ie_o = ie_q;

  AST_IE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i || cls_i == CLS_NONE || cls_i == CLS_NOP || cls_i == CLS_RFE || cls_i == CLS_MFC0)
    |=> $stable(ie_o)) else $error("enable bit moved without cause"); // R12

endmodule

// File: rtl/cop0_cmd_decoder.sv
module cop0_cmd_decoder
  import cop0_cmd_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int DATA_W     = 32,
  parameter int IE_BIT     = 16,
  parameter int STATUS_IDX = 12,
  parameter int PC_STEP    = 4,
  parameter bit EI_SETS_IE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid_i,
  input  logic [31:0]       instr_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              mt_ie_i,
  output logic              retire_o,
  output logic              is_mfc0_o,
  output logic              is_mtc0_o,
  output logic              is_rfe_o,
  output logic              is_ei_o,
  output logic              is_di_o,
  output logic              is_nop_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [4:0]        gpr_idx_o,
  output logic              status_ie_o,
  output logic              unsup_o,
  output logic [PC_W-1:0]   unsup_pc_o,
  output logic [31:0]       unsup_instr_o
);

  localparam int          NUM_CLS    = 6;
  localparam logic [4:0]  STATUS_SEL = 5'(STATUS_IDX);
  localparam logic [PC_W-1:0] STEP   = PC_W'(PC_STEP);

  cmd_cls_e   cls;
  logic [4:0] rd_idx;
  logic [4:0] rt_idx;
  logic       ie_cur;

  cop0_cmd_classify u_classify (
    .instr_i  (instr_i),
    .cls_o    (cls),
    .rd_idx_o (rd_idx),
    .rt_idx_o (rt_idx)
  );

  cop0_status_ie #(
    .STATUS_IDX (STATUS_IDX),
    .EI_SETS_IE (EI_SETS_IE)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (instr_valid_i),
    .cls_i    (cls),
    .rd_idx_i (rd_idx),
    .mt_ie_i  (mt_ie_i),
    .ie_o     (ie_cur)
  );

  logic                retire_q,  retire_d;
  logic                unsup_q,   unsup_d;
  logic [NUM_CLS-1:0]  flags_q,   flags_d;
  logic [PC_W-1:0]     npc_q,     npc_d;
  logic [DATA_W-1:0]   rdata_q,   rdata_d;
  logic [4:0]          gidx_q,    gidx_d;
  logic [PC_W-1:0]     upc_q,     upc_d;
  logic [31:0]         uins_q,    uins_d;

  always_comb begin
    retire_d = instr_valid_i && (cls != CLS_NONE);
    unsup_d  = instr_valid_i && (cls == CLS_NONE);

    flags_d = '0;
    if (retire_d) begin
      flags_d[0] = (cls == CLS_MFC0);
      flags_d[1] = (cls == CLS_MTC0);
      flags_d[2] = (cls == CLS_RFE);
      flags_d[3] = (cls == CLS_EI);
      flags_d[4] = (cls == CLS_DI);
      flags_d[5] = (cls == CLS_NOP);
    end

    npc_d = retire_d ? (pc_i + STEP) : npc_q;

    rdata_d = '0;
    if (retire_d && cls == CLS_MFC0 && rd_idx == STATUS_SEL) begin
      rdata_d[IE_BIT] = ie_cur;
    end

    gidx_d = (retire_d && (cls == CLS_MFC0 || cls == CLS_MTC0)) ? rt_idx : 5'd0;

    upc_d  = unsup_d ? pc_i    : upc_q;
    uins_d = unsup_d ? instr_i : uins_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retire_q <= 1'b0;
      unsup_q  <= 1'b0;
      flags_q  <= '0;
      rdata_q  <= '0;
      gidx_q   <= '0;
    end else begin
      retire_q <= retire_d;
      unsup_q  <= unsup_d;
      flags_q  <= flags_d;
      rdata_q  <= rdata_d;
      gidx_q   <= gidx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npc_q <= '0;
    end else if (retire_d) begin
      npc_q <= npc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc_q  <= '0;
      uins_q <= '0;
    end else if (unsup_d) begin
      upc_q  <= upc_d;
      uins_q <= uins_d;
    end
  end

  assign retire_o      = retire_q;
  assign unsup_o       = unsup_q;
  assign is_mfc0_o     = flags_q[0];
  assign is_mtc0_o     = flags_q[1];
  assign is_rfe_o      = flags_q[2];
  assign is_ei_o       = flags_q[3];
  assign is_di_o       = flags_q[4];
  assign is_nop_o      = flags_q[5];
  assign next_pc_o     = npc_q;
  assign rdata_o       = rdata_q;
  assign gpr_idx_o     = gidx_q;
  assign status_ie_o   = ie_cur;
  assign unsup_pc_o    = upc_q;
  assign unsup_instr_o = uins_q;

  AST_RETIRE_UNSUP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_o && unsup_o)) else $error("retire and unsupported together"); // R10
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    retire_o |-> $countones({is_mfc0_o, is_mtc0_o, is_rfe_o, is_ei_o, is_di_o, is_nop_o}) == 1)
    else $error("retire without a single class"); // R11
  AST_NO_CLASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_o |-> !(is_mfc0_o || is_mtc0_o || is_rfe_o || is_ei_o || is_di_o || is_nop_o))
    else $error("class flag without retire"); // R11
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    retire_o |-> next_pc_o == $past(pc_i) + STEP) else $error("next PC wrong"); // R3
  AST_UNSUP_HOLD_PC: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_o |-> $stable(next_pc_o)) else $error("unsupported moved PC"); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid_i |=> (!retire_o && !unsup_o)) else $error("output without valid"); // R12

endmodule

// File: tb/cop0_cmd_decoder_tb.sv
`timescale 1ns/1ps
module cop0_cmd_decoder_tb;

  logic        clk;
  logic        rst_n;
  logic        instr_valid_i;
  logic [31:0] instr_i;
  logic [31:0] pc_i;
  logic        mt_ie_i;
  logic        retire_o, is_mfc0_o, is_mtc0_o, is_rfe_o, is_ei_o, is_di_o, is_nop_o;
  logic [31:0] next_pc_o, rdata_o, unsup_pc_o, unsup_instr_o;
  logic [4:0]  gpr_idx_o;
  logic        status_ie_o, unsup_o;

  int n_chk;
  int n_bad;
  bit finished;

  logic        exp_ie;
  logic [31:0] exp_npc;

  cop0_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .pc_i(pc_i), .mt_ie_i(mt_ie_i), .retire_o(retire_o), .is_mfc0_o(is_mfc0_o),
    .is_mtc0_o(is_mtc0_o), .is_rfe_o(is_rfe_o), .is_ei_o(is_ei_o), .is_di_o(is_di_o),
    .is_nop_o(is_nop_o), .next_pc_o(next_pc_o), .rdata_o(rdata_o), .gpr_idx_o(gpr_idx_o),
    .status_ie_o(status_ie_o), .unsup_o(unsup_o), .unsup_pc_o(unsup_pc_o),
    .unsup_instr_o(unsup_instr_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] enc(input logic [5:0] opc, input logic [4:0] sel,
                                      input logic [4:0] rt, input logic [4:0] rd,
                                      input logic [5:0] fn);
    return {opc, sel, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [5:0] flags();
    return {is_mfc0_o, is_mtc0_o, is_rfe_o, is_ei_o, is_di_o, is_nop_o};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Drive one word for one cycle; results are sampled one falling edge later.
  task automatic issue(input logic [31:0] w, input logic [31:0] pc, input logic mt);
    @(negedge clk);
    instr_i = w; pc_i = pc; mt_ie_i = mt; instr_valid_i = 1'b1;
    @(negedge clk);
    instr_valid_i = 1'b0;
  endtask

  task automatic expect_retire(input string req, input logic [5:0] fl, input logic [31:0] pc);
    exp_npc = pc + 32'd4;
    check(retire_o === 1'b1 && unsup_o === 1'b0, req, {30'd0, retire_o, unsup_o}, 32'h2);
    check(flags() === fl, req, {26'd0, flags()}, {26'd0, fl});
    check(next_pc_o === exp_npc, req, next_pc_o, exp_npc);
    check(status_ie_o === exp_ie, req, {31'd0, status_ie_o}, {31'd0, exp_ie});
  endtask

  task automatic t_reset;
    check(retire_o === 1'b0 && unsup_o === 1'b0, "R1", {30'd0, retire_o, unsup_o}, 32'd0);
    check(flags() === 6'd0, "R1", {26'd0, flags()}, 32'd0);
    check(status_ie_o === 1'b0, "R1", {31'd0, status_ie_o}, 32'd0);
    check(next_pc_o === 32'd0, "R1", next_pc_o, 32'd0);
  endtask

  task automatic t_ei;
    issue(32'h4200_0038, 32'h0010_00FC, 1'b0);
    exp_ie = 1'b1;
    expect_retire("R3 R4 EI", 6'b000100, 32'h0010_00FC);
    check(next_pc_o === 32'h0010_0100, "R3", next_pc_o, 32'h0010_0100);
  endtask

  task automatic t_mfc0;
    issue(enc(6'h10, 5'h00, 5'd2, 5'd12, 6'h00), 32'h0000_2000, 1'b0);
    expect_retire("R6 MFC0", 6'b100000, 32'h0000_2000);
    check(rdata_o === {15'd0, exp_ie, 16'd0}, "R6 status read", rdata_o, {15'd0, exp_ie, 16'd0});
    check(gpr_idx_o === 5'd2, "R6 gpr", {27'd0, gpr_idx_o}, 32'd2);
    issue(enc(6'h10, 5'h00, 5'd7, 5'd9, 6'h00), 32'h0000_2004, 1'b0);
    expect_retire("R6 MFC0 other", 6'b100000, 32'h0000_2004);
    check(rdata_o === 32'd0, "R6 other read", rdata_o, 32'd0);
  endtask

  task automatic t_di;
    issue(enc(6'h10, 5'h10, 5'd0, 5'd0, 6'h39), 32'h0000_3000, 1'b0);
    exp_ie = 1'b0;
    expect_retire("R5 DI", 6'b000010, 32'h0000_3000);
  endtask

  task automatic t_mtc0;
    issue(enc(6'h10, 5'h04, 5'd3, 5'd12, 6'h00), 32'h0000_4000, 1'b1);
    exp_ie = 1'b1;
    expect_retire("R7 MTC0 set", 6'b010000, 32'h0000_4000);
    issue(enc(6'h10, 5'h04, 5'd3, 5'd11, 6'h00), 32'h0000_4004, 1'b0);
    expect_retire("R7 MTC0 other reg", 6'b010000, 32'h0000_4004);
    issue(enc(6'h10, 5'h04, 5'd3, 5'd12, 6'h00), 32'h0000_4008, 1'b0);
    exp_ie = 1'b0;
    expect_retire("R7 MTC0 clear", 6'b010000, 32'h0000_4008);
  endtask

  task automatic t_rfe;
    issue(32'h4200_0038, 32'h0000_5000, 1'b0);
    exp_ie = 1'b1;
    expect_retire("R3 EI again", 6'b000100, 32'h0000_5000);
    issue(enc(6'h10, 5'h10, 5'd0, 5'd0, 6'h10), 32'h0000_5004, 1'b0);
    expect_retire("R8 RFE", 6'b001000, 32'h0000_5004);
  endtask

  task automatic t_nop;
    logic [5:0] fns [6];
    fns = '{6'h01, 6'h02, 6'h06, 6'h08, 6'h18, 6'h20};
    for (int i = 0; i < 6; i++) begin
      issue(enc(6'h10, 5'h10, 5'd0, 5'd0, fns[i]), 32'h0000_6000 + 32'(i * 4), 1'b0);
      expect_retire("R9 NOP", 6'b000001, 32'h0000_6000 + 32'(i * 4));
    end
  endtask

  task automatic t_unsup_one(input logic [31:0] w, input logic [31:0] pc, input string req);
    logic [31:0] held;
    held = exp_npc;
    issue(w, pc, 1'b1);
    check(unsup_o === 1'b1 && retire_o === 1'b0, req, {30'd0, retire_o, unsup_o}, 32'h1);
    check(unsup_pc_o === pc, req, unsup_pc_o, pc);
    check(unsup_instr_o === w, req, unsup_instr_o, w);
    check(next_pc_o === held, req, next_pc_o, held);
    check(status_ie_o === exp_ie && flags() === 6'd0, req, {31'd0, status_ie_o}, {31'd0, exp_ie});
  endtask

  task automatic t_unsup;
    t_unsup_one(enc(6'h11, 5'h10, 5'd0, 5'd0, 6'h39), 32'h0000_7000, "R2 R10 other opcode");
    t_unsup_one(enc(6'h10, 5'h11, 5'd0, 5'd0, 6'h39), 32'h0000_7004, "R2 R10 other group");
    t_unsup_one(enc(6'h10, 5'h10, 5'd0, 5'd0, 6'h3A), 32'h0000_7008, "R10 unknown function");
    t_unsup_one(32'h4200_0078, 32'h0000_700C, "R2 R10 command pad bits");
    t_unsup_one(enc(6'h10, 5'h04, 5'd1, 5'd12, 6'h01), 32'h0000_7010, "R2 R10 move pad bits");
  endtask

  task automatic t_idle;
    @(negedge clk);
    instr_i = enc(6'h10, 5'h10, 5'd0, 5'd0, 6'h39); pc_i = 32'h0000_8000;
    instr_valid_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(retire_o === 1'b0 && unsup_o === 1'b0, "R12 idle", {30'd0, retire_o, unsup_o}, 32'd0);
      check(status_ie_o === exp_ie, "R12 idle enable", {31'd0, status_ie_o}, {31'd0, exp_ie});
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    exp_ie = 1'b0; exp_npc = 32'd0;
    rst_n = 1'b0; instr_valid_i = 1'b0; instr_i = '0; pc_i = '0; mt_ie_i = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ei();
    t_mfc0();
    t_di();
    t_mfc0();
    t_mtc0();
    t_rfe();
    t_nop();
    t_unsup();
    t_idle();
    summary();
  end

endmodule